// File: doc/BRIEF.md
# Threshold-Gated Priority Selector for One Interrupt Target

This block picks, for a single interrupt target, which interrupt source to present next. Each cycle it combines a per-source pending vector with a per-source enable vector. Among the sources that are both pending and enabled, it finds the one with the highest priority. When several share the top priority, the lowest-numbered source wins. The result is registered into two outputs: a request line and the number of the winning source.

Sources are numbered from 1, and the number 0 means that no source is selected. The number output always tracks the best candidate, even when that candidate's priority does not clear the target threshold. The request line rises only when the winner's priority is strictly greater than the threshold. Software can therefore see which source is waiting while the target is still masked.

Two selection structures are available through a parameter: a balanced comparison tree and a linear scan. Both must give identical results. The number of sources and the priority width are also parameters, and their legal values are checked at elaboration.

Top module: `irq_target_arb`

## Requirements
- R1: A source takes part in selection only when its enable bit and its pending bit are both 1. A pending but disabled source has no effect on either output.
- R2: One clock edge after the best candidate has a priority strictly greater than the threshold, the request output is 1.
- R3: On every cycle where the request output is 1, the number output is nonzero and equals the 1-based number of the winning source. Source bit i maps to number i+1.
- R4: The number output shows the best candidate one edge later, even when that candidate's priority is less than or equal to the threshold. In that case the request output is 0.
- R5: Among candidates that share the highest priority, the one with the lowest number wins.
- R6: With no candidate, one edge later the number output is 0 and the request output is 0.
- R7: A winner with priority 0 never raises the request, whatever the threshold.
- R8: While reset is asserted, the request output is 0 and the number output is 0, whatever the inputs.
- R9: The tree structure (SEL_MODE = ARB_TREE) and the linear structure (SEL_MODE = ARB_LINEAR) give the same outputs for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_SRC | Pending bit per source, bit i is source number i+1 |
| en_i | input | N_SRC | Enable bit per source |
| prio_i | input | N_SRC*PRIO_W | Priority per source, source i in bits [i*PRIO_W +: PRIO_W] |
| thr_i | input | PRIO_W | Target threshold |
| irq_o | output | 1 | Registered request |
| irq_id_o | output | $clog2(N_SRC+1) | Registered number of the best candidate, 0 when none |

## Verification
The bench builds two copies of the block, each with four sources and 2-bit priorities: one with the tree structure and one with the linear structure. At this size the sweep covers all 256 priority assignments against all 16 candidate patterns, with the threshold varied. That reaches every tie pattern, every threshold relation and every zero-priority winner. A second sweep walks all enable and pending combinations under a fixed priority set, which separates the effect of pending alone from that of a true candidate.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic {
      ARB_TREE   = 1'b0,
      ARB_LINEAR = 1'b1
   } arb_mode_e;

   function automatic int id_width(input int n_src);
      return $clog2(n_src + 1);
   endfunction

endpackage

// File: rtl/irq_arb_cand.sv
module irq_arb_cand #(
   parameter int N_SRC = 4
) (
   input  logic [N_SRC-1:0] pend_i,
   input  logic [N_SRC-1:0] en_i,
   output logic [N_SRC-1:0] cand_o
);

   for (genvar g = 0; g < N_SRC; g++) begin : g_mask
      assign cand_o[g] = pend_i[g] & en_i[g];
   end

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
   import irq_arb_pkg::*;
#(
   parameter int        N_SRC    = 4,
   parameter int        PRIO_W   = 2,
   parameter arb_mode_e SEL_MODE = ARB_TREE,
   localparam int       IDW      = id_width(N_SRC)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [N_SRC-1:0]        cand_i,
   input  logic [N_SRC*PRIO_W-1:0] prio_i,
   output logic                    sel_valid_o,
   output logic [PRIO_W-1:0]       sel_prio_o,
   output logic [IDW-1:0]          sel_id_o
);

   localparam int LVL    = (N_SRC > 1) ? $clog2(N_SRC) : 0;
   localparam int LEAVES = 1 << LVL;
   localparam int NODES  = 2 * LEAVES - 1;
   localparam int IDSPAN = 1 << IDW;

   if (SEL_MODE == ARB_TREE) begin : g_tree
      logic              nv [NODES];
      logic [PRIO_W-1:0] np [NODES];
      logic [IDW-1:0]    ni [NODES];

      for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
         if (j < N_SRC) begin : g_real
            assign nv[LEAVES-1+j] = cand_i[j];
            assign np[LEAVES-1+j] = prio_i[j*PRIO_W +: PRIO_W];
            assign ni[LEAVES-1+j] = IDW'(j + 1);
         end else begin : g_pad
            assign nv[LEAVES-1+j] = 1'b0;
            assign np[LEAVES-1+j] = '0;
            assign ni[LEAVES-1+j] = '0;
         end
      end

      for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
         logic take_left;
         // the left subtree holds the lower numbers, so it wins ties
         assign take_left = nv[2*k+1] &
                            (~nv[2*k+2] | (np[2*k+1] >= np[2*k+2]));
         assign nv[k] = nv[2*k+1] | nv[2*k+2];
         assign np[k] = take_left ? np[2*k+1] : np[2*k+2];
         assign ni[k] = take_left ? ni[2*k+1] :
                        (nv[2*k+2] ? ni[2*k+2] : '0);
      end

      assign sel_valid_o = nv[0];
      assign sel_prio_o  = nv[0] ? np[0] : '0;
      assign sel_id_o    = nv[0] ? ni[0] : '0;
   end else begin : g_linear
      always_comb begin
         sel_valid_o = 1'b0;
         sel_prio_o  = '0;
         sel_id_o    = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (cand_i[i] &&
                (!sel_valid_o || (prio_i[i*PRIO_W +: PRIO_W] > sel_prio_o))) begin
               sel_valid_o = 1'b1;
               sel_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
               sel_id_o    = IDW'(i + 1);
            end
         end
      end
   end

   logic [IDSPAN-1:0] cand_by_id;
   assign cand_by_id = IDSPAN'({cand_i, 1'b0});

   // R1: the chosen number always names a true candidate
   a_r1_win_is_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o |-> cand_by_id[sel_id_o]);

   // R6: a winner exists exactly when some candidate exists
   a_r6_valid_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o == (|cand_i));

endmodule

// File: rtl/irq_arb_out.sv
module irq_arb_out #(
   parameter int PRIO_W = 2,
   parameter int IDW    = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_valid_i,
   input  logic [PRIO_W-1:0] sel_prio_i,
   input  logic [IDW-1:0]    sel_id_i,
   input  logic [PRIO_W-1:0] thr_i,
   output logic              irq_o,
   output logic [IDW-1:0]    irq_id_o
);

   logic above;
   assign above = sel_valid_i & (sel_prio_i > thr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_o    <= 1'b0;
         irq_id_o <= '0;
      end else begin
         irq_o    <= above;
         irq_id_o <= sel_valid_i ? sel_id_i : '0;
      end
   end

   a_r2_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_i && (sel_prio_i > thr_i)) |=> irq_o);

   a_r3_irq_has_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (irq_id_o != '0));

   a_r4_id_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_i |=> (irq_id_o == $past(sel_id_i)));

   a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_valid_i |=> (!irq_o && irq_id_o == '0));

   a_r7_zero_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_i && sel_prio_i == '0) |=> !irq_o);

endmodule

// File: rtl/irq_target_arb.sv
module irq_target_arb
   import irq_arb_pkg::*;
#(
   parameter int        N_SRC    = 4,
   parameter int        PRIO_W   = 2,
   parameter arb_mode_e SEL_MODE = ARB_TREE,
   localparam int       IDW      = id_width(N_SRC)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [N_SRC-1:0]        pend_i,
   input  logic [N_SRC-1:0]        en_i,
   input  logic [N_SRC*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]       thr_i,
   output logic                    irq_o,
   output logic [IDW-1:0]          irq_id_o
);

   if (N_SRC < 1) begin : g_bad_src
      $error("irq_target_arb: N_SRC must be at least 1");
   end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
      $error("irq_target_arb: PRIO_W must lie in 1..16");
   end

   logic [N_SRC-1:0]  cand;
   logic              sel_valid;
   logic [PRIO_W-1:0] sel_prio;
   logic [IDW-1:0]    sel_id;

   irq_arb_cand #(.N_SRC(N_SRC)) u_cand (
      .pend_i (pend_i),
      .en_i   (en_i),
      .cand_o (cand)
   );

   irq_arb_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SEL_MODE(SEL_MODE)) u_sel (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cand_i      (cand),
      .prio_i      (prio_i),
      .sel_valid_o (sel_valid),
      .sel_prio_o  (sel_prio),
      .sel_id_o    (sel_id)
   );

   irq_arb_out #(.PRIO_W(PRIO_W), .IDW(IDW)) u_out (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_valid_i (sel_valid),
      .sel_prio_i  (sel_prio),
      .sel_id_i    (sel_id),
      .thr_i       (thr_i),
      .irq_o       (irq_o),
      .irq_id_o    (irq_id_o)
   );

   // R8: the outputs are held at zero while reset is active
   a_r8_reset_quiet: assert property (@(posedge clk_i)
      !rst_ni |-> (!irq_o && irq_id_o == '0));

endmodule

// File: tb/irq_target_arb_tb.sv
module irq_target_arb_tb;
   import irq_arb_pkg::*;

   localparam int N  = 4;
   localparam int PW = 2;
   localparam int IW = id_width(N);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    pend = '0;
   logic [N-1:0]    en = '0;
   logic [N*PW-1:0] prio = '0;
   logic [PW-1:0]   thr = '0;
   logic            irq_t, irq_l;
   logic [IW-1:0]   id_t, id_l;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   irq_target_arb #(.N_SRC(N), .PRIO_W(PW), .SEL_MODE(ARB_TREE)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
      .thr_i(thr), .irq_o(irq_t), .irq_id_o(id_t));

   irq_target_arb #(.N_SRC(N), .PRIO_W(PW), .SEL_MODE(ARB_LINEAR)) u_lin (
      .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
      .thr_i(thr), .irq_o(irq_l), .irq_id_o(id_l));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (pend=%b en=%b prio=%b thr=%0d)",
                  req, act, exp, pend, en, prio, thr);
      end
   endtask

   // expected outputs, from the requirements
   task automatic apply_and_check(input logic [N-1:0] p, input logic [N-1:0] e,
                                  input logic [N*PW-1:0] pr, input logic [PW-1:0] t,
                                  input bit r1_case);
      int best_id, best_p, ties;
      bit exp_irq;
      string tag;
      @(negedge clk);
      pend = p; en = e; prio = pr; thr = t;
      best_id = 0; best_p = -1; ties = 0;
      for (int i = 0; i < N; i++) begin
         if (p[i] && e[i]) begin
            int v = int'(pr[i*PW +: PW]);
            if (v > best_p) begin best_p = v; best_id = i + 1; ties = 0; end
            else if (v == best_p) ties++;
         end
      end
      exp_irq = (best_id != 0) && (best_p > int'(t));
      if (r1_case)           tag = "R1";
      else if (best_id == 0) tag = "R6";
      else if (ties > 0)     tag = "R5";
      else if (exp_irq)      tag = "R2/R3";
      else if (best_p == 0)  tag = "R7";
      else                   tag = "R4";
      @(negedge clk);
      chk({tag, " irq"}, int'(irq_t), int'(exp_irq));
      chk({tag, " id"},  int'(id_t),  best_id);
      chk("R9 linear irq", int'(irq_l), int'(exp_irq));
      chk("R9 linear id",  int'(id_l),  best_id);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      // R8: reset holds outputs low even with eager inputs
      pend = '1; en = '1; prio = '1; thr = '0;
      repeat (3) @(negedge clk);
      chk("R8 irq", int'(irq_t), 0);
      chk("R8 id",  int'(id_t),  0);
      chk("R8 linear irq", int'(irq_l), 0);
      pend = '0; en = '0; prio = '0;
      @(negedge clk);
      rst_n = 1'b1;

      // all priority maps against all candidate patterns
      for (int pv = 0; pv < 256; pv++) begin
         for (int c = 0; c < 16; c++) begin
            apply_and_check(N'(c), '1, (N*PW)'(pv), PW'((pv ^ c) + (pv >> 4)), 1'b0);
         end
      end

      // R1: every enable/pending pairing under a fixed priority map
      for (int e = 0; e < 16; e++) begin
         for (int p = 0; p < 16; p++) begin
            apply_and_check(N'(p), N'(e), 8'b10_01_11_10, 2'd1, 1'b1);
         end
      end

      // R1: disabled high-priority pending source beside a low enabled one
      apply_and_check(4'b1001, 4'b0001, 8'b11_00_00_01, 2'd0, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule